// File: doc/BRIEF.md
# Color-Line Command Decoder with Trigger Pulse Generator

This block turns colored screen lines into commands and timed output pulses. A host draws a solid-colored line in each video frame. Comparators ahead of this block reduce each color channel to one logic level. The block samples that three-bit color once per frame, on the selected edge of the vertical sync. It then classifies the color and steps a small mode machine through three phases. In the first phase the machine is armed. In the second it collects a pulse length one bit at a time. In the third it turns picture changes into output pulses.

Each picture change seen in the flipping phase fires one output pulse. The pulse is as long as the loaded length, counted in clock cycles. The host has three ways to stop a frame that is only redrawn from being read as a new symbol. A symbol counts only when the frame color differs from the color of the previous frame. A white frame sits between two equal symbols. The start sequence needs three distinct colors in order.

Top module: `color_cmd_pulser`

## Requirements
- R1: All four video inputs (red, green, blue and vsync) pass through a chain of at least two flip-flops (`SYNC_STAGES`, default 2) before any logic uses them. With the default chain, a vsync edge driven between two clock edges raises `pulse_out` after the fourth rising clock edge.
- R2: The color code is {R,G,B}. Red = 100, green = 010 and blue = 001 are pure colors, and at most one pure flag is ever set. The complementary colors are cyan = 011, magenta = 101 and yellow = 110. White is 111.
- R3: From idle, the block reaches the loading phase only after the new colors magenta, cyan and white arrive in that order. Any other new color during this sequence returns the block to idle.
- R4: In the loading phase, cyan shifts in a 0 and yellow shifts in a 1, least significant bit first. The length register is cleared when loading starts.
- R5: White in the loading phase adds no bit. It separates two equal consecutive bits, so that both are counted.
- R6: Magenta in the loading phase enters the flipping phase. Pure green in the flipping phase returns the block to idle.
- R7: In the flipping phase, a new red or blue frame fires exactly one pulse. Other colors in the flipping phase fire nothing. Red and blue outside the flipping phase fire nothing.
- R8: A frame whose sampled color equals the previous frame's sampled color has no effect.
- R9: `vsync_rise_sel` = 1 samples the color on the rising vsync edge. `vsync_rise_sel` = 0 samples it on the falling edge.
- R10: The output pulse stays high for exactly the stored length in clock cycles.
- R11: Bits received after the `LEN_W`-th bit of a load are discarded.
- R12: A trigger that arrives while a pulse is active is ignored. A stored length of zero produces no pulse.
- R13: Reset puts the block in idle with `pulse_out` low and the last color set to black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| vid_r | input | 1 | Red channel level from the comparator (asynchronous) |
| vid_g | input | 1 | Green channel level from the comparator (asynchronous) |
| vid_b | input | 1 | Blue channel level from the comparator (asynchronous) |
| vid_vsync | input | 1 | Vertical sync (asynchronous) |
| vsync_rise_sel | input | 1 | 1: sample on the rising vsync edge; 0: sample on the falling edge |
| pulse_out | output | 1 | Timed output pulse |

## Verification
The bench uses the default parameters, `LEN_W` = 16 and `SYNC_STAGES` = 2. With a 16-bit register, a 17-bit load that proves the extra bit is discarded takes only a few dozen frames. With the two-stage chain, the edge-to-pulse delay is a fixed four clocks, which the bench checks cycle by cycle. Loaded lengths of 40 cycles are longer than one bench frame, so a second picture change arrives while the first pulse is still high.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [2:0] {
    COL_BLACK   = 3'b000,
    COL_BLUE    = 3'b001,
    COL_GREEN   = 3'b010,
    COL_CYAN    = 3'b011,
    COL_RED     = 3'b100,
    COL_MAGENTA = 3'b101,
    COL_YELLOW  = 3'b110,
    COL_WHITE   = 3'b111
  } color_e;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_ARM_M = 3'd1,
    MD_ARM_C = 3'd2,
    MD_LOAD  = 3'd3,
    MD_FLIP  = 3'd4
  } mode_e;

  typedef struct packed {
    logic red;
    logic green;
    logic blue;
    logic cyan;
    logic magenta;
    logic yellow;
    logic white;
  } color_flags_t;

endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
  end

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/ccp_color_class.sv
module ccp_color_class
  import ccp_pkg::*;
(
  input  logic         r,
  input  logic         g,
  input  logic         b,
  output color_e       color,
  output color_flags_t flags
);
  always_comb begin
    color         = color_e'({r, g, b});
    flags.red     =  r & ~g & ~b;
    flags.green   = ~r &  g & ~b;
    flags.blue    = ~r & ~g &  b;
    flags.cyan    = ~r &  g &  b;
    flags.magenta =  r & ~g &  b;
    flags.yellow  =  r &  g & ~b;
    flags.white   =  r &  g &  b;
  end
endmodule

// File: rtl/ccp_mode_fsm.sv
module ccp_mode_fsm
  import ccp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_evt,
  input  color_e           color,
  input  color_flags_t     flags,
  output logic [LEN_W-1:0] len_o,
  output logic             trig_o
);
  localparam int CNT_W = $clog2(LEN_W + 1);

  mode_e            mode_q, mode_d;
  color_e           last_q;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic             trig_q, trig_d;
  logic             new_sym, ins, ins_bit, clr;

  assign new_sym = frame_evt && (color != last_q);

  // next-state decode
  always_comb begin
    mode_d  = mode_q;
    ins     = 1'b0;
    ins_bit = 1'b0;
    clr     = 1'b0;
    trig_d  = 1'b0;
    if (new_sym) begin
      unique case (mode_q)
        MD_IDLE:  if (flags.magenta) mode_d = MD_ARM_M;
        MD_ARM_M: mode_d = flags.cyan ? MD_ARM_C : MD_IDLE;
        MD_ARM_C: begin
          if (flags.white) begin
            mode_d = MD_LOAD;
            clr    = 1'b1;
          end else begin
            mode_d = MD_IDLE;
          end
        end
        MD_LOAD: begin
          if (flags.cyan) begin
            ins = 1'b1;
          end else if (flags.yellow) begin
            ins     = 1'b1;
            ins_bit = 1'b1;
          end else if (flags.magenta) begin
            mode_d = MD_FLIP;
          end
        end
        MD_FLIP: begin
          if (flags.red || flags.blue) trig_d = 1'b1;
          else if (flags.green)        mode_d = MD_IDLE;
        end
        default: mode_d = MD_IDLE;
      endcase
    end
  end

  // length shift register, LSB first, saturating bit index
  always_comb begin
    len_d     = len_q;
    bit_cnt_d = bit_cnt_q;
    if (clr) begin
      len_d     = '0;
      bit_cnt_d = '0;
    end else if (ins && (bit_cnt_q < CNT_W'(LEN_W))) begin
      for (int i = 0; i < LEN_W; i++)
        if (bit_cnt_q == CNT_W'(i)) len_d[i] = ins_bit;
      bit_cnt_d = bit_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_IDLE;
      last_q    <= COL_BLACK;
      len_q     <= '0;
      bit_cnt_q <= '0;
      trig_q    <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      len_q     <= len_d;
      bit_cnt_q <= bit_cnt_d;
      trig_q    <= trig_d;
      if (frame_evt) last_q <= color;
    end
  end

  assign len_o  = len_q;
  assign trig_o = trig_q;

  // R8: a redrawn frame changes neither trigger nor stored length
  p_redraw_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && color == last_q) |=> (!trig_q && $stable(len_q)));

  // R7: triggers leave only from the flipping phase
  p_trig_in_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(mode_q == MD_FLIP));

  // R11: bits past the register width leave it untouched
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && bit_cnt_q == CNT_W'(LEN_W)) |=> $stable(len_q));
endmodule

// File: rtl/ccp_pulse_gen.sv
module ccp_pulse_gen #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             pulse_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             start;

  assign start   = trig && (cnt_q == '0) && (len != '0);
  assign pulse_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = len;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: an accepted trigger loads the full stored width
  p_start_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !pulse_o && len != '0) |=> (pulse_o && cnt_q == $past(len)));

  // R12: a trigger during an active pulse does not restart it
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && pulse_o) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

  // R12: zero length never raises the output
  p_zero_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !pulse_o && len == '0) |=> !pulse_o);
endmodule

// File: rtl/color_cmd_pulser.sv
module color_cmd_pulser
  import ccp_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vid_r,
  input  logic vid_g,
  input  logic vid_b,
  input  logic vid_vsync,
  input  logic vsync_rise_sel,
  output logic pulse_out
);
  localparam int IN_W = 4;

  logic [IN_W-1:0]  in_s;
  logic             vs_q;
  logic             frame_evt;
  color_e           color;
  color_flags_t     flags;
  logic [LEN_W-1:0] len;
  logic             trig;

  // R1: every video input goes through the synchronizer chain
  ccp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({vid_r, vid_g, vid_b, vid_vsync}),
    .q     (in_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= in_s[0];
  end

  assign frame_evt = vsync_rise_sel ? (in_s[0] & ~vs_q) : (~in_s[0] & vs_q);

  ccp_color_class u_class (
    .r     (in_s[3]),
    .g     (in_s[2]),
    .b     (in_s[1]),
    .color (color),
    .flags (flags)
  );

  // R2: pure-color flags are mutually exclusive
  p_pure_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.red, flags.green, flags.blue}));

  ccp_mode_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_evt (frame_evt),
    .color     (color),
    .flags     (flags),
    .len_o     (len),
    .trig_o    (trig)
  );

  ccp_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .len     (len),
    .pulse_o (pulse_out)
  );
endmodule

// File: tb/tb_color_cmd_pulser.sv
module tb_color_cmd_pulser;
  localparam logic [2:0] K = 3'b000, B = 3'b001, G = 3'b010, C = 3'b011,
                         R = 3'b100, M = 3'b101, Y = 3'b110, W = 3'b111;

  typedef struct packed {
    logic [2:0] col;
    int         cnt;
    int         wid;
    int         req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{R, 0, 0, 7},  // R7 red while idle
    '{M, 0, 0, 3},  // R3 arm step 1
    '{C, 0, 0, 3},  // R3 arm step 2
    '{W, 0, 0, 3},  // R3 arm step 3, loading starts
    '{Y, 0, 0, 4},  // R4 bit0 = 1
    '{W, 0, 0, 5},  // R5 separator
    '{C, 0, 0, 4},  // R4 bit1 = 0
    '{W, 0, 0, 5},
    '{Y, 0, 0, 4},  // R4 bit2 = 1 -> length 5
    '{M, 0, 0, 6},  // R6 enter flipping
    '{R, 1, 5, 10}, // R10 width 5
    '{R, 0, 0, 8},  // R8 redraw
    '{B, 1, 5, 7},
    '{R, 1, 5, 7},
    '{W, 0, 0, 7},
    '{R, 1, 5, 7},
    '{G, 0, 0, 6},  // R6 back to idle
    '{R, 0, 0, 6},
    '{B, 0, 0, 6},
    '{M, 0, 0, 3},
    '{C, 0, 0, 3},
    '{W, 0, 0, 3},
    '{Y, 0, 0, 5},
    '{W, 0, 0, 5},
    '{Y, 0, 0, 5},  // two equal bits -> length 3
    '{M, 0, 0, 6},
    '{B, 1, 3, 4},  // R4 cleared at load start: 3, not 7
    '{G, 0, 0, 6}
  };

  logic clk = 1'b0;
  logic rst_n, vid_r, vid_g, vid_b, vid_vsync, vsync_rise_sel;
  logic pulse_out;

  int n_checks = 0, n_fail = 0;
  int rises = 0, highs = 0;
  logic prev_p = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  color_cmd_pulser dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .vid_r          (vid_r),
    .vid_g          (vid_g),
    .vid_b          (vid_b),
    .vid_vsync      (vid_vsync),
    .vsync_rise_sel (vsync_rise_sel),
    .pulse_out      (pulse_out)
  );

  always @(negedge clk) begin
    if (pulse_out && !prev_p) rises <= rises + 1;
    if (pulse_out)            highs <= highs + 1;
    prev_p <= pulse_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame2(input logic [2:0] c_rise, input logic [2:0] c_fall);
    @(negedge clk) {vid_r, vid_g, vid_b} = c_rise;
    repeat (4) @(negedge clk);
    vid_vsync = 1'b1;
    repeat (3) @(negedge clk);
    {vid_r, vid_g, vid_b} = c_fall;
    repeat (3) @(negedge clk);
    vid_vsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] c);
    frame2(c, c);
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic expect_pulses(input int r0, input int h0, input int cnt, input int wid,
                               input string req);
    check(rises - r0 == cnt, req, rises - r0, cnt);
    if (cnt > 0) check(highs - h0 == cnt * wid, req, highs - h0, cnt * wid);
  endtask

  task automatic load_len(input int value, input int nbits);
    frame(M); frame(C); frame(W);
    for (int i = 0; i < nbits; i++) begin
      frame(((value >> i) & 1) != 0 ? Y : C);
      frame(W);
    end
    frame(M);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, h0;
    rst_n = 1'b0; vid_r = 0; vid_g = 0; vid_b = 0; vid_vsync = 0; vsync_rise_sel = 1'b1;
    repeat (5) @(negedge clk);
    check(pulse_out == 1'b0, "R13 reset output", pulse_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R13 after reset", pulse_out, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      r0 = rises; h0 = highs;
      frame(TBL[v].col);
      settle();
      expect_pulses(r0, h0, TBL[v].cnt, TBL[v].wid, $sformatf("R%0d vec%0d", TBL[v].req, v));
    end

    // R3: broken arming sequences leave the block idle
    r0 = rises; h0 = highs;
    frame(M); frame(R); frame(C); frame(W); frame(Y); frame(M); frame(B);
    frame(M); frame(C); frame(Y); frame(M); frame(R);
    settle();
    expect_pulses(r0, h0, 0, 0, "R3 aborted arming");
    frame(G);

    // R12: zero length produces no pulse
    load_len(0, 0);
    r0 = rises; h0 = highs;
    frame(R); settle();
    expect_pulses(r0, h0, 0, 0, "R12 zero length");
    frame(G);

    // R11: seventeenth bit discarded (value 0x10002 -> width 2)
    load_len(32'h10002, 17);
    r0 = rises; h0 = highs;
    frame(R); settle();
    expect_pulses(r0, h0, 1, 2, "R11 overflow bit dropped");
    frame(G);

    // R12: retrigger during an active 40-cycle pulse ignored
    load_len(40, 6);
    r0 = rises; h0 = highs;
    frame(R); frame(B); settle();
    expect_pulses(r0, h0, 1, 40, "R12 busy retrigger");
    r0 = rises; h0 = highs;
    frame(R); settle();
    expect_pulses(r0, h0, 1, 40, "R10 retrigger after idle");

    // R9: falling-edge sampling
    @(negedge clk) vsync_rise_sel = 1'b0;
    r0 = rises; h0 = highs;
    frame2(B, R); settle();
    expect_pulses(r0, h0, 0, 0, "R9 falling edge sees red");
    r0 = rises; h0 = highs;
    frame2(R, B); settle();
    expect_pulses(r0, h0, 1, 40, "R9 falling edge sees blue");
    @(negedge clk) vsync_rise_sel = 1'b1;
    r0 = rises; h0 = highs;
    frame2(R, B); settle();
    expect_pulses(r0, h0, 1, 40, "R9 rising edge sees red");

    // R1: exact latency from vsync edge through the two-stage chain
    @(negedge clk) {vid_r, vid_g, vid_b} = B;
    repeat (4) @(negedge clk);
    vid_vsync = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check(pulse_out == 1'b0, $sformatf("R1 low at clock %0d", k), pulse_out, 0);
    end
    @(negedge clk);
    check(pulse_out == 1'b1, "R1 high at clock 4", pulse_out, 1);
    repeat (4) @(negedge clk);
    vid_vsync = 1'b0;
    settle();

    // R13: reset mid-run returns to idle
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R13 output low in reset", pulse_out, 0);
    rst_n = 1'b1;
    r0 = rises; h0 = highs;
    frame(R); settle();
    expect_pulses(r0, h0, 0, 0, "R13 idle after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule